// File: doc/BRIEF.md
# Full-Speed USB Turnaround Timeout Detector

This block sits behind the line decoder of a full-speed USB host port and judges whether a device answered in time. After the host finishes a packet and a reply is expected, control logic pulses `arm`. The detector then waits for the single-ended-zero phase of the host's end-of-packet. Its timing reference is the cycle in which the line returns from SE0 to idle (J). From there it counts bit times, delivered as `bit_en` pulses by a clock recovery stage. It watches for the idle-to-K transition that opens the device's start of packet.

If the K arrives first, the block emits a one-cycle `sop_seen` pulse. If the number of counted bit times reaches the threshold `TA_LIMIT` first, the block raises `ta_timeout`. `TA_LIMIT` is chosen between 16 and 18 bit times. The timeout flag is the status of that one transaction and stays high until the next `arm`. Only one of the two outcomes is reported per arm. After reporting, the detector ignores the line until it is armed again.

All inputs are sampled on the rising clock edge. Both outputs are registered, so they appear one cycle after the sample that caused them. There is no data stream at this block's edge, so every pin is plain control or status and no back-pressure applies.

Top module: `usb_turnaround_watch`

## Requirements
- R1: A synchronous `rst` clears the count, the armed state and both outputs. While `rst` is high, both outputs read 0 at the next edge, and a J-to-K change seen after reset without an `arm` produces no output.
- R2: After `arm`, no bit time is counted until the line has shown SE0 (`line_state` = 2'b00) and then idle J (`line_state` = 2'b01). The J sample is count zero. `bit_en` pulses before it do not count.
- R3: While counting, the count advances only in cycles with `bit_en` high. `ta_timeout` goes high one cycle after the cycle that carries the `TA_LIMIT`-th counted pulse, unless that cycle ends counting for another reason.
- R4: While counting, a sample of K (`line_state` = 2'b10) whose previous sample was J is a start of packet. `sop_seen` is high for exactly the following cycle.
- R5: SE0 sampled while counting stops the count. Counting restarts from zero at the next J sample.
- R6: `sop_seen` and `ta_timeout` never both occur for one arm. After either one, no further output occurs until the next `arm`.
- R7: `ta_timeout` stays high until the next `arm` or `rst`. It reads 0 in the cycle after `arm` is sampled.
- R8: An `arm` sampled while waiting or counting restarts the sequence from the wait for SE0, with the count cleared.
- R9: If a start of packet and the `TA_LIMIT`-th counted pulse fall in the same cycle, the start of packet wins: `sop_seen` pulses and `ta_timeout` stays 0.
- R10: The code 2'b11 is neither SE0, J nor K. It does not stop the count. It breaks a J-to-K pair, so a K right after it is not a start of packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Pulse: a response is expected, start a new watch |
| bit_en | input | 1 | One-cycle pulse per recovered bit time |
| line_state | input | 2 | Decoded line: 00 SE0, 01 J (idle), 10 K, 11 invalid |
| sop_seen | output | 1 | One-cycle pulse: device start of packet seen in time |
| ta_timeout | output | 1 | Turnaround timeout status, held until next arm |

## Verification
The bench builds two copies side by side on the same stimulus: `u_dut` with `TA_LIMIT` = 18 and a second copy with `TA_LIMIT` = 16. This puts both ends of the allowed range under test. A K placed after 16 or 17 counted bit times therefore lands as a timeout in one copy and as an in-time start of packet in the other. That exposes the exact threshold cycle and the same-cycle priority of R9 in a single run.

// File: rtl/uta_pkg.sv
package uta_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_BAD = 2'b11
  } line_code_e;

  typedef enum logic [1:0] {
    ST_OFF      = 2'b00,
    ST_WAIT_SE0 = 2'b01,
    ST_WAIT_J   = 2'b10,
    ST_COUNT    = 2'b11
  } watch_state_e;

endpackage

// File: rtl/uta_line_tracker.sv
module uta_line_tracker
  import uta_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_state,
  output logic       is_se0,
  output logic       is_j,
  output logic       k_after_j
);

  logic [1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= LS_SE0;
    else     line_q <= line_state;
  end

  assign is_se0    = (line_state == LS_SE0);
  assign is_j      = (line_state == LS_J);
  assign k_after_j = (line_q == LS_J) && (line_state == LS_K);

endmodule

// File: rtl/uta_bit_counter.sv
module uta_bit_counter #(
  parameter int LIMIT = 17,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);

  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (inc)    cnt <= last ? '0 : cnt + 1'b1;
  end

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT));

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(cnt));

endmodule

// File: rtl/uta_ctrl.sv
module uta_ctrl
  import uta_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic bit_en,
  input  logic is_se0,
  input  logic is_j,
  input  logic k_after_j,
  input  logic last,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic sop_seen,
  output logic ta_timeout
);

  watch_state_e state, state_n;
  logic sop_n, to_n;

  always_comb begin
    state_n = state;
    sop_n   = 1'b0;
    to_n    = ta_timeout;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (arm) begin
      state_n = ST_WAIT_SE0;
      to_n    = 1'b0;
      cnt_clr = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: ;
        ST_WAIT_SE0: if (is_se0) state_n = ST_WAIT_J;
        ST_WAIT_J: begin
          if (is_j) begin
            state_n = ST_COUNT;
            cnt_clr = 1'b1;
          end
        end
        ST_COUNT: begin
          if (is_se0) begin
            state_n = ST_WAIT_J;
          end else if (k_after_j) begin
            sop_n   = 1'b1;
            state_n = ST_OFF;
          end else if (bit_en) begin
            cnt_inc = 1'b1;
            if (last) begin
              to_n    = 1'b1;
              state_n = ST_OFF;
            end
          end
        end
        default: state_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      sop_seen   <= 1'b0;
      ta_timeout <= 1'b0;
    end else begin
      state      <= state_n;
      sop_seen   <= sop_n;
      ta_timeout <= to_n;
    end
  end

  a_r6_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(sop_seen && ta_timeout));

  a_r4_sop_single_cycle: assert property (@(posedge clk) disable iff (rst)
    sop_seen |=> !sop_seen);

  a_r7_arm_clears_flag: assert property (@(posedge clk) disable iff (rst)
    arm |=> !ta_timeout);

  a_r3_timeout_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(ta_timeout) |-> $past(bit_en));

  a_r6_silent_when_off: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OFF && !arm) |=> (!sop_seen && $stable(ta_timeout)));

endmodule

// File: rtl/usb_turnaround_watch.sv
module usb_turnaround_watch #(
  parameter int TA_LIMIT = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       arm,
  input  logic       bit_en,
  input  logic [1:0] line_state,
  output logic       sop_seen,
  output logic       ta_timeout
);

  generate
    if (TA_LIMIT < 16 || TA_LIMIT > 18) begin : g_bad_limit
      $error("TA_LIMIT must lie between 16 and 18");
    end
  endgenerate

  logic is_se0, is_j, k_after_j, last, cnt_clr, cnt_inc;

  uta_line_tracker u_line (
    .clk        (clk),
    .rst        (rst),
    .line_state (line_state),
    .is_se0     (is_se0),
    .is_j       (is_j),
    .k_after_j  (k_after_j)
  );

  uta_bit_counter #(.LIMIT(TA_LIMIT)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .last (last)
  );

  uta_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .bit_en     (bit_en),
    .is_se0     (is_se0),
    .is_j       (is_j),
    .k_after_j  (k_after_j),
    .last       (last),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .sop_seen   (sop_seen),
    .ta_timeout (ta_timeout)
  );

endmodule

// File: tb/usb_turnaround_watch_tb.sv
module usb_turnaround_watch_tb;

  localparam int LIM_HI = 18;
  localparam int LIM_LO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0;
  logic bit_en = 1'b0;
  logic [1:0] line_state = 2'b01;
  logic sop_hi, to_hi, sop_lo, to_lo;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_turnaround_watch #(.TA_LIMIT(LIM_HI)) u_dut (
    .clk(clk), .rst(rst), .arm(arm), .bit_en(bit_en), .line_state(line_state),
    .sop_seen(sop_hi), .ta_timeout(to_hi));

  usb_turnaround_watch #(.TA_LIMIT(LIM_LO)) u_dut_lo (
    .clk(clk), .rst(rst), .arm(arm), .bit_en(bit_en), .line_state(line_state),
    .sop_seen(sop_lo), .ta_timeout(to_lo));

  // Reference model, one per copy: 0 off, 1 wait SE0, 2 wait J, 3 counting
  int m_st[2];
  int m_cnt[2];
  logic [1:0] m_prev[2];
  bit e_sop[2];
  bit e_to[2];

  function automatic int lim_of(input int k);
    return (k == 0) ? LIM_HI : LIM_LO;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_st[k] = 0; m_cnt[k] = 0; e_sop[k] = 0; e_to[k] = 0; m_prev[k] = 2'b00;
      end else begin
        e_sop[k] = 0;
        if (arm) begin
          m_st[k] = 1; m_cnt[k] = 0; e_to[k] = 0;
        end else if (m_st[k] == 1) begin
          if (line_state == 2'b00) m_st[k] = 2;
        end else if (m_st[k] == 2) begin
          if (line_state == 2'b01) begin m_st[k] = 3; m_cnt[k] = 0; end
        end else if (m_st[k] == 3) begin
          if (line_state == 2'b00) m_st[k] = 2;
          else if (m_prev[k] == 2'b01 && line_state == 2'b10) begin
            e_sop[k] = 1; m_st[k] = 0;
          end else if (bit_en) begin
            m_cnt[k]++;
            if (m_cnt[k] == lim_of(k)) begin e_to[k] = 1; m_st[k] = 0; end
          end
        end
        m_prev[k] = line_state;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Continuous comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(e_to[0] ? "R3" : "R6", to_hi, e_to[0], "model ta_timeout hi");
      check(e_sop[0] ? "R4" : "R6", sop_hi, e_sop[0], "model sop_seen hi");
      check(e_to[1] ? "R3" : "R6", to_lo, e_to[1], "model ta_timeout lo");
      check(e_sop[1] ? "R4" : "R6", sop_lo, e_sop[1], "model sop_seen lo");
    end
  end

  task automatic step(input logic [1:0] l, input logic a, input logic b);
    line_state = l; arm = a; bit_en = b;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(2'b01, 1'b0, 1'b1);
  endtask

  task automatic start_count();
    step(2'b01, 1'b1, 1'b0);
    step(2'b00, 1'b0, 1'b1);
    step(2'b01, 1'b0, 1'b1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1", to_hi, 1'b0, "reset ta_timeout");
    check("R1", sop_hi, 1'b0, "reset sop_seen");
    rst = 1'b0;
    step(2'b00, 1'b0, 1'b1);
    step(2'b01, 1'b0, 1'b1);
    step(2'b10, 1'b0, 1'b1);
    check("R1", sop_hi, 1'b0, "no sop without arm");

    // R2: pulses before SE0/J are not counted
    step(2'b01, 1'b1, 1'b0);
    ticks(20);
    check("R2", to_hi, 1'b0, "no count before SE0");
    step(2'b00, 1'b0, 1'b1);
    step(2'b01, 1'b0, 1'b1);
    ticks(15);
    check("R3", to_lo, 1'b0, "lo before threshold");
    ticks(1);
    check("R3", to_lo, 1'b1, "lo at 16 ticks");
    check("R3", to_hi, 1'b0, "hi at 16 ticks");
    step(2'b01, 1'b0, 1'b0);
    check("R3", to_hi, 1'b0, "no count without bit_en");
    ticks(1);
    check("R3", to_hi, 1'b0, "hi at 17 ticks");
    ticks(1);
    check("R3", to_hi, 1'b1, "hi at 18 ticks");
    step(2'b01, 1'b0, 1'b0);
    step(2'b10, 1'b0, 1'b0);
    check("R6", sop_hi, 1'b0, "no sop after timeout");
    check("R7", to_hi, 1'b1, "flag held");
    step(2'b01, 1'b1, 1'b0);
    check("R7", to_hi, 1'b0, "arm clears flag");

    // R9: sop in the same cycle as the last tick
    step(2'b00, 1'b0, 1'b0);
    step(2'b01, 1'b0, 1'b0);
    ticks(17);
    step(2'b10, 1'b0, 1'b1);
    check("R9", sop_hi, 1'b1, "sop wins hi");
    check("R9", to_hi, 1'b0, "no timeout hi");
    check("R3", to_lo, 1'b1, "lo timed out earlier");
    step(2'b01, 1'b0, 1'b0);
    check("R4", sop_hi, 1'b0, "sop one cycle only");

    // R5: SE0 during counting restarts
    start_count();
    ticks(15);
    step(2'b00, 1'b0, 1'b1);
    step(2'b01, 1'b0, 1'b1);
    ticks(15);
    check("R5", to_lo, 1'b0, "restart after SE0");
    ticks(1);
    check("R5", to_lo, 1'b1, "timeout after restart");

    // R8: arm mid-count restarts from wait for SE0
    start_count();
    ticks(10);
    step(2'b01, 1'b1, 1'b1);
    ticks(20);
    check("R8", to_lo, 1'b0, "rearm waits for SE0");

    // R10: code 11 breaks J-to-K, does not stop count
    start_count();
    ticks(5);
    step(2'b11, 1'b0, 1'b1);
    step(2'b10, 1'b0, 1'b0);
    check("R10", sop_lo, 1'b0, "K after 11 not sop");
    step(2'b01, 1'b0, 1'b0);
    step(2'b10, 1'b0, 1'b0);
    check("R4", sop_lo, 1'b1, "J then K is sop");

    // Random transactions checked by the model
    for (int s = 0; s < 400; s++) begin
      int n;
      start_count();
      n = 10 + int'($urandom_range(0, 12));
      for (int i = 0; i < n; i++) begin
        int r;
        r = int'($urandom_range(0, 99));
        if (r < 3) step(2'b00, 1'b0, 1'b0);
        else if (r < 5) step(2'b11, 1'b0, 1'b1);
        else if (r < 7) step(2'b10, 1'b0, 1'b1);
        else step(2'b01, 1'b0, ($urandom_range(0, 3) != 0));
      end
      step(($urandom_range(0, 1) != 0) ? 2'b10 : 2'b01, 1'b0, 1'b1);
      step(2'b01, 1'b0, 1'b0);
    end
    for (int i = 0; i < 3000; i++)
      step(2'($urandom_range(0, 3)), ($urandom_range(0, 60) == 0), ($urandom_range(0, 1) != 0));
    finish_run();
  end

endmodule